// File: doc/BRIEF.md
# Per-Channel Diagnostic Fault Latch

This block sits between the analog fault comparators of a four-channel low-side driver and its serial status path. For every channel it watches three raw flags: current limit or over-temperature, open load and short to ground. It qualifies each flag against the commanded state of that channel's output, and requires the resulting condition to persist for a programmable number of clock cycles. Only then does it store a two-bit status code.

The stored codes form an eight-bit diagnostic word that the serial interface shifts out. Two signals are derived from that word. One is a one-bit-per-channel health vector. The other is an active-low general fault line, suitable for interrupting a host controller.

The serial interface issues a one-cycle clear pulse when a frame ends. That pulse returns every channel to the normal code. It also restarts all qualification timing, so a fault that is still present is reported again only after a complete fresh interval.

Top module: `diag_fault_latch`

## Requirements
- R1: After synchronous reset, `diag_o` is 8'hFF, `chan_ok_o` is 4'hF and `any_fault_n_o` is 1.
- R2: Channel n (0 to 3) reports in `diag_o[2n+1:2n]`. The code values are:
  - 2'b11: normal.
  - 2'b10: overload, short to supply or over-temperature.
  - 2'b01: open load.
  - 2'b00: short to ground.
- R3: A condition is latched at the QUAL_CYC-th consecutive rising edge at which it is sampled, and `diag_o` changes just after that edge. If the condition is absent at any edge before then, its count restarts and nothing is latched.
- R4: The open-load and short-to-ground flags count only while `out_on_i` for that channel is 0. The overload flag counts only while `out_on_i` is 1. A flag outside its window has no effect.
- R5: When short to ground and open load are both flagged on a switched-off channel, the channel qualifies and latches short to ground (2'b00).
- R6: A newer condition that completes its own qualification overwrites the code already latched for that channel.
- R7: A clear pulse sets `diag_o` to 8'hFF at the next edge and restarts every count. A condition that stays present is latched again exactly QUAL_CYC edges after the clear edge.
- R8: When a clear is sampled at the same edge at which a condition would complete qualification, the clear wins and the channel reads normal.
- R9: `chan_ok_o[n]` is 1 when channel n holds the normal code and 0 when it holds any fault code.
- R10: `any_fault_n_o` is 0 whenever any channel holds a fault code, in the same cycle as `diag_o`.
- R11: A latched code stays unchanged after its raw flag disappears, until a clear or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | One-cycle clear pulse from end of serial frame |
| out_on_i | input | 4 | Commanded on state per channel |
| ovl_i | input | 4 | Raw current-limit / over-temperature flag per channel |
| open_i | input | 4 | Raw open-load flag per channel |
| sgnd_i | input | 4 | Raw short-to-ground flag per channel |
| diag_o | output | 8 | Latched two-bit code per channel |
| chan_ok_o | output | 4 | Per-channel health, 1 = no fault |
| any_fault_n_o | output | 1 | Active-low general fault |

## Verification
Several properties are checked on every cycle:
- every new code can be traced to a raw flag that was valid for the commanded output state in the preceding cycle;
- a channel returns to normal only after a clear;
- a clear always empties the word;
- the health vector and the general fault line always agree with the latched word.

The exact qualification length, its restart when a flag drops out early, the priority between simultaneous off-state flags, the overwrite by a newer fault, and a clear beating a same-edge qualification all depend on multi-cycle histories. These are shown only by the bench's directed scenarios and its reference model running under random stimulus.

// File: rtl/diag_latch_pkg.sv
package diag_latch_pkg;

    typedef enum logic [1:0] {
        DC_SHORT_GND = 2'b00,
        DC_OPEN      = 2'b01,
        DC_OVERLOAD  = 2'b10,
        DC_NORMAL    = 2'b11
    } diag_code_e;

    typedef struct packed {
        logic ovl;
        logic opn;
        logic sgnd;
        logic on;
    } chan_sense_t;

    // Gate raw flags by commanded state, then apply fixed priority.
    function automatic diag_code_e classify(chan_sense_t s);
        if (s.on) begin
            return s.ovl ? DC_OVERLOAD : DC_NORMAL;
        end
        if (s.sgnd) begin
            return DC_SHORT_GND;
        end
        if (s.opn) begin
            return DC_OPEN;
        end
        return DC_NORMAL;
    endfunction

    function automatic logic is_fault(logic [1:0] c);
        return c != DC_NORMAL;
    endfunction

endpackage

// File: rtl/chan_qualifier.sv
module chan_qualifier
    import diag_latch_pkg::*;
#(
    parameter int QUAL_CYC = 13750
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  chan_sense_t sense,
    output diag_code_e  code_o
);

    localparam int CNT_W = $clog2(QUAL_CYC + 1);
    localparam logic [CNT_W-1:0] QUAL_MAX = CNT_W'(QUAL_CYC);
    localparam logic [CNT_W-1:0] QUAL_M1  = CNT_W'(QUAL_CYC - 1);

    diag_code_e       cand;
    diag_code_e       cand_q;
    diag_code_e       latch_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] run;
    logic [CNT_W-1:0] run_next;
    logic             qualified;

    always_comb begin
        cand = classify(sense);
        // Edges already seen with this same candidate.
        if (cand != DC_NORMAL && cand == cand_q) begin
            run = cnt_q;
        end else begin
            run = '0;
        end
        qualified = (cand != DC_NORMAL) && (run >= QUAL_M1);
        if (cand == DC_NORMAL) begin
            run_next = '0;
        end else if (run == QUAL_MAX) begin
            run_next = run;
        end else begin
            run_next = run + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q   <= '0;
            cand_q  <= DC_NORMAL;
            latch_q <= DC_NORMAL;
        end else begin
            cnt_q  <= run_next;
            cand_q <= cand;
            if (qualified) begin
                latch_q <= cand;
            end
        end
    end

    assign code_o = latch_q;

endmodule

// File: rtl/fault_summary.sv
module fault_summary
    import diag_latch_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic [2*NUM_CH-1:0] diag,
    output logic [NUM_CH-1:0]   chan_ok,
    output logic                any_fault_n
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ok
        assign chan_ok[g] = !is_fault(diag[2*g +: 2]);
    end

    assign any_fault_n = &chan_ok;

endmodule

// File: rtl/diag_fault_latch.sv
module diag_fault_latch
    import diag_latch_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int QUAL_CYC = 13750
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr_i,
    input  logic [NUM_CH-1:0]   out_on_i,
    input  logic [NUM_CH-1:0]   ovl_i,
    input  logic [NUM_CH-1:0]   open_i,
    input  logic [NUM_CH-1:0]   sgnd_i,
    output logic [2*NUM_CH-1:0] diag_o,
    output logic [NUM_CH-1:0]   chan_ok_o,
    output logic                any_fault_n_o
);

    diag_code_e code_w [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        chan_sense_t sense;
        assign sense.ovl  = ovl_i[g];
        assign sense.opn  = open_i[g];
        assign sense.sgnd = sgnd_i[g];
        assign sense.on   = out_on_i[g];

        chan_qualifier #(.QUAL_CYC(QUAL_CYC)) qual_i (
            .clk    (clk),
            .rst    (rst),
            .clr    (clr_i),
            .sense  (sense),
            .code_o (code_w[g])
        );

        assign diag_o[2*g +: 2] = code_w[g];
    end

    fault_summary #(.NUM_CH(NUM_CH)) summ_i (
        .diag        (diag_o),
        .chan_ok     (chan_ok_o),
        .any_fault_n (any_fault_n_o)
    );

endmodule

// File: rtl/diag_fault_latch_chk.sv
module diag_fault_latch_chk #(
    parameter int NUM_CH = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                clr_i,
    input logic [NUM_CH-1:0]   out_on_i,
    input logic [NUM_CH-1:0]   ovl_i,
    input logic [NUM_CH-1:0]   open_i,
    input logic [NUM_CH-1:0]   sgnd_i,
    input logic [2*NUM_CH-1:0] diag_o,
    input logic [NUM_CH-1:0]   chan_ok_o,
    input logic                any_fault_n_o
);

    AST_RESET_NORMAL: assert property (@(posedge clk) rst |=> (diag_o == '1)); // R1

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (diag_o == '1)); // R7

    AST_FAULTN_AGREES: assert property (@(posedge clk) disable iff (rst)
        any_fault_n_o == (diag_o == '1)); // R10

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        AST_OPEN_NEEDS_OFF: assert property (@(posedge clk) disable iff (rst)
            (diag_o[2*i +: 2] == 2'b01 && $past(diag_o[2*i +: 2]) != 2'b01)
            |-> $past(open_i[i] && !sgnd_i[i] && !out_on_i[i])); // R4

        AST_SGND_NEEDS_OFF: assert property (@(posedge clk) disable iff (rst)
            (diag_o[2*i +: 2] == 2'b00 && $past(diag_o[2*i +: 2]) != 2'b00)
            |-> $past(sgnd_i[i] && !out_on_i[i])); // R5

        AST_OVL_NEEDS_ON: assert property (@(posedge clk) disable iff (rst)
            (diag_o[2*i +: 2] == 2'b10 && $past(diag_o[2*i +: 2]) != 2'b10)
            |-> $past(ovl_i[i] && out_on_i[i])); // R4

        AST_STICKY_UNTIL_CLEAR: assert property (@(posedge clk) disable iff (rst)
            (diag_o[2*i +: 2] == 2'b11 && $past(diag_o[2*i +: 2]) != 2'b11)
            |-> $past(clr_i)); // R11

        AST_OK_AGREES: assert property (@(posedge clk) disable iff (rst)
            chan_ok_o[i] == (diag_o[2*i +: 2] == 2'b11)); // R9
    end

endmodule

bind diag_fault_latch diag_fault_latch_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .clr_i         (clr_i),
    .out_on_i      (out_on_i),
    .ovl_i         (ovl_i),
    .open_i        (open_i),
    .sgnd_i        (sgnd_i),
    .diag_o        (diag_o),
    .chan_ok_o     (chan_ok_o),
    .any_fault_n_o (any_fault_n_o)
);

// File: tb/diag_fault_latch_tb_top.sv
`timescale 1ns/1ps
module diag_fault_latch_tb_top;

    localparam int Q = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clr_i = 1'b0;
    logic [3:0] out_on_i = '0;
    logic [3:0] ovl_i = '0;
    logic [3:0] open_i = '0;
    logic [3:0] sgnd_i = '0;
    logic [7:0] diag_o;
    logic [3:0] chan_ok_o;
    logic       any_fault_n_o;

    int    checks = 0;
    int    failures = 0;
    bit    chk_en = 1'b0;
    bit    done = 1'b0;
    string tag = "R1";

    int       run_m  [4];
    logic [1:0] prev_m [4];
    logic [1:0] lat_m  [4];

    always #4 clk = ~clk;

    diag_fault_latch #(.NUM_CH(4), .QUAL_CYC(Q)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .clr_i         (clr_i),
        .out_on_i      (out_on_i),
        .ovl_i         (ovl_i),
        .open_i        (open_i),
        .sgnd_i        (sgnd_i),
        .diag_o        (diag_o),
        .chan_ok_o     (chan_ok_o),
        .any_fault_n_o (any_fault_n_o)
    );

    // Expected candidate code from requirements R2, R4 and R5.
    function automatic logic [1:0] cand_of(logic on, logic ov, logic op, logic sg);
        if (on) return ov ? 2'b10 : 2'b11;
        if (sg) return 2'b00;
        if (op) return 2'b01;
        return 2'b11;
    endfunction

    function automatic logic [3:0] ok_of(logic [7:0] d);
        logic [3:0] r;
        for (int c = 0; c < 4; c++) r[c] = (d[2*c +: 2] == 2'b11);
        return r;
    endfunction

    // Reference model: count consecutive edges per candidate (R3, R6, R7, R8).
    always @(posedge clk) begin
        for (int c = 0; c < 4; c++) begin
            logic [1:0] cd;
            cd = cand_of(out_on_i[c], ovl_i[c], open_i[c], sgnd_i[c]);
            if (rst || clr_i) begin
                run_m[c] = 0; prev_m[c] = 2'b11; lat_m[c] = 2'b11;
            end else begin
                if (cd == 2'b11) run_m[c] = 0;
                else if (cd == prev_m[c]) run_m[c] = (run_m[c] < Q) ? run_m[c] + 1 : Q;
                else run_m[c] = 1;
                if (cd != 2'b11 && run_m[c] >= Q) lat_m[c] = cd;
                prev_m[c] = cd;
            end
        end
    end

    task automatic check_state(string t, logic [7:0] ed);
        checks++;
        if (diag_o !== ed || chan_ok_o !== ok_of(ed) || any_fault_n_o !== (ed == 8'hFF)) begin
            failures++;
            $display("FAIL %s diag=%h ok=%b fn=%b expected diag=%h ok=%b fn=%b",
                     t, diag_o, chan_ok_o, any_fault_n_o, ed, ok_of(ed), ed == 8'hFF);
        end
    endtask

    always @(negedge clk) begin
        if (chk_en && !done) begin
            check_state({tag, " model"}, {lat_m[3], lat_m[2], lat_m[1], lat_m[0]});
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive(logic [3:0] on, logic [3:0] ov, logic [3:0] op, logic [3:0] sg, logic cl);
        out_on_i = on; ovl_i = ov; open_i = op; sgnd_i = sg; clr_i = cl;
    endtask

    initial begin
        void'($urandom(32'd424242));
        tick(3);
        rst = 1'b0;
        tick(1);
        check_state("R1 reset", 8'hFF);
        chk_en = 1'b1;

        tag = "R3";
        drive(4'h0, 4'h0, 4'b0010, 4'h0, 0); tick(4);
        drive(4'h0, 4'h0, 4'h0, 4'h0, 0); tick(1);
        check_state("R3 early drop", 8'hFF);

        tag = "R2";
        drive(4'h0, 4'h0, 4'b0010, 4'h0, 0); tick(4);
        check_state("R3 one edge short", 8'hFF);
        tick(1);
        check_state("R2 R9 R10 open ch1", 8'hF7);

        tag = "R11";
        drive(4'h0, 4'h0, 4'h0, 4'h0, 0); tick(6);
        check_state("R11 held", 8'hF7);

        tag = "R4";
        drive(4'h0, 4'b1000, 4'h0, 4'h0, 0); tick(8);
        check_state("R4 ovl while off", 8'hF7);
        drive(4'b1000, 4'b1000, 4'h0, 4'b1000, 0); tick(5);
        check_state("R4 ovl while on, sgnd ignored", 8'hB7);

        tag = "R7";
        drive(4'b1000, 4'b1000, 4'h0, 4'h0, 1); tick(1);
        check_state("R7 clear", 8'hFF);
        drive(4'b1000, 4'b1000, 4'h0, 4'h0, 0); tick(4);
        check_state("R7 fresh interval", 8'hFF);
        tick(1);
        check_state("R7 relatch", 8'hBF);

        tag = "R5";
        drive(4'h0, 4'h0, 4'b0001, 4'b0001, 0); tick(5);
        check_state("R5 sgnd over open", 8'hBC);
        tag = "R6";
        drive(4'h0, 4'h0, 4'b0001, 4'h0, 0); tick(5);
        check_state("R6 overwrite", 8'hBD);

        tag = "R8";
        drive(4'h0, 4'h0, 4'h0, 4'h0, 1); tick(1);
        drive(4'h0, 4'h0, 4'b0100, 4'h0, 0); tick(4);
        drive(4'h0, 4'h0, 4'b0100, 4'h0, 1); tick(1);
        check_state("R8 clear wins", 8'hFF);
        drive(4'h0, 4'h0, 4'b0100, 4'h0, 0); tick(4);
        check_state("R8 restart", 8'hFF);
        tick(1);
        check_state("R8 relatch R9", 8'hDF);

        tag = "R3 R4 R5 R6 R7 random";
        for (int k = 0; k < 400; k++) begin
            logic [3:0] on, ov, op, sg;
            for (int c = 0; c < 4; c++) begin
                on[c] = $urandom % 2;
                ov[c] = ($urandom % 3) == 0;
                op[c] = ($urandom % 3) == 0;
                sg[c] = ($urandom % 4) == 0;
            end
            drive(on, ov, op, sg, (($urandom % 8) == 0));
            tick(1);
            clr_i = 1'b0;
            tick(int'($urandom % 9));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule